// File: doc/BRIEF.md
# Event Routing and Queue Engine

The engine takes interrupt notifications, one source number at a time, and routes each through two lookup levels. The source number selects an assignment entry. That entry either masks the source or names a notification descriptor and supplies a 31-bit event data word. The descriptor gives a target CPU, a priority from 0 to 7, and a circular event queue held in a small internal memory. For a routed event the engine stores the data word at the queue's current slot, tagged with the queue's generation bit, and then raises a one-cycle presentation request carrying the CPU and the priority.

Both tables are register arrays written through simple write ports. Writing a descriptor also restarts its queue. The queue memory can be read through a combinational port, so the consumer can see new entries by watching the generation bit flip. It needs no head or tail registers for this. Notifications are handled strictly one at a time. The ready output is low from acceptance until the event has finished.

Top module: `evt_route_engine`

## Requirements
- R1: After reset, notifyReady is 1, presValid is 0 and errSticky is 0.
- R2: A notification is accepted on a clock edge where notifyValid and notifyReady are both 1. notifyReady then stays 0 for 4 cycles for a routed event, or for 2 cycles for a masked or invalid one.
- R3: A source whose assignment entry has the mask bit set causes no queue write, no presentation and no error, and its queue index is not advanced.
- R4: A routed event writes the word {toggle, data}, with the toggle in bit 31 and the 31-bit assignment data in bits 30:0. The word goes to memory address (descriptor base + current index) modulo the memory depth.
- R5: After each write the descriptor's index increments. When the index reaches the descriptor's entry count it becomes 0 and the toggle bit inverts.
- R6: Exactly one presValid pulse, one cycle long, follows each routed event, in the cycle after the queue write (the third edge after acceptance). presCpu and presPrio carry that descriptor's CPU and priority.
- R7: If the assignment entry names a descriptor whose valid bit is 0, the event is dropped with no write and no presentation. errSticky is set two edges after acceptance and stays set until reset.
- R8: Writing a descriptor sets that queue's index to 0 and its toggle to 1.
- R9: Several sources that share one descriptor fill its queue in acceptance order, each with its own data word.
- R10: notifyValid asserted while notifyReady is 0 is ignored. Nothing is written or presented for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| notifyValid | input | 1 | Notification offered |
| notifySrc | input | 4 | Source number |
| notifyReady | output | 1 | Engine idle, can take a notification |
| asnWrEn | input | 1 | Write assignment entry |
| asnWrSrc | input | 4 | Assignment entry index |
| asnWrMask | input | 1 | Mask bit for the entry |
| asnWrDesc | input | 2 | Descriptor selected by the entry |
| asnWrData | input | 31 | Event data word for the entry |
| descWrEn | input | 1 | Write descriptor (also restarts its queue) |
| descWrIdx | input | 2 | Descriptor index |
| descWrValid | input | 1 | Descriptor valid bit |
| descWrCpu | input | 2 | Target CPU |
| descWrPrio | input | 3 | Priority 0..7 |
| descWrBase | input | 6 | Queue base address in memory |
| descWrSize | input | 7 | Queue entry count (1..64) |
| qRdAddr | input | 6 | Queue memory read address |
| qRdData | output | 32 | Queue memory word at qRdAddr |
| presValid | output | 1 | Presentation request pulse |
| presCpu | output | 2 | CPU of the request |
| presPrio | output | 3 | Priority of the request |
| errSticky | output | 1 | Invalid descriptor was hit |

## Verification
The hardest states to reach are the wrap of a queue, where the index returns to 0 and the toggle flips, and the case where a rejected notification is held high during a busy period. The stimulus reaches the wrap quickly by giving one queue a single entry and another queue three entries shared by two sources. It then holds notifyValid high with a different source number throughout a routed event. A behavioural model of indexes, toggles and memory predicts every cycle of ready, presentation and error, and predicts every queue word.

// File: rtl/erq_pkg.sv
package erq_pkg;
  localparam int DATA_W = 31;
  localparam int PRIO_W = 3;

  typedef struct packed {
    logic latchSrc;
    logic latchAsn;
    logic qWrite;
    logic setErr;
  } erq_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_WRITE,
    ST_PRES
  } erq_state_t;
endpackage

// File: rtl/erq_ctrl.sv
module erq_ctrl
  import erq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        notifyValid,
  input  logic        asnMasked,
  input  logic        descValid,
  output logic        notifyReady,
  output logic        presValid,
  output erq_strobe_t strobes
);
  erq_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (notifyValid) stateNext = ST_FETCH;
      ST_FETCH: stateNext = ST_CHECK;
      ST_CHECK: stateNext = (asnMasked || !descValid) ? ST_IDLE : ST_WRITE;
      ST_WRITE: stateNext = ST_PRES;
      ST_PRES:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.latchSrc = (state == ST_IDLE) && notifyValid;
    strobes.latchAsn = (state == ST_FETCH);
    strobes.qWrite   = (state == ST_WRITE);
    strobes.setErr   = (state == ST_CHECK) && !asnMasked && !descValid;
  end

  assign notifyReady = (state == ST_IDLE);
  assign presValid   = (state == ST_PRES);

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (notifyReady && notifyValid) |=> !notifyReady);
  // R6
  pres_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    presValid |=> !presValid);
  // R6
  write_then_pres_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.qWrite |=> presValid);
  // R3
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && asnMasked) |=> (notifyReady && !strobes.qWrite));
endmodule

// File: rtl/erq_datapath.sv
module erq_datapath
  import erq_pkg::*;
#(
  parameter int NUM_SRC    = 16,
  parameter int NUM_DESC   = 4,
  parameter int NUM_CPU    = 4,
  parameter int QMEM_DEPTH = 64,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int DESC_W = $clog2(NUM_DESC),
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int QA_W   = $clog2(QMEM_DEPTH),
  localparam int CNT_W  = QA_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  erq_strobe_t         strobes,
  input  logic [SRC_W-1:0]    notifySrc,
  input  logic                asnWrEn,
  input  logic [SRC_W-1:0]    asnWrSrc,
  input  logic                asnWrMask,
  input  logic [DESC_W-1:0]   asnWrDesc,
  input  logic [DATA_W-1:0]   asnWrData,
  input  logic                descWrEn,
  input  logic [DESC_W-1:0]   descWrIdx,
  input  logic                descWrValid,
  input  logic [CPU_W-1:0]    descWrCpu,
  input  logic [PRIO_W-1:0]   descWrPrio,
  input  logic [QA_W-1:0]     descWrBase,
  input  logic [CNT_W-1:0]    descWrSize,
  input  logic [QA_W-1:0]     qRdAddr,
  output logic [31:0]         qRdData,
  output logic [CPU_W-1:0]    presCpu,
  output logic [PRIO_W-1:0]   presPrio,
  output logic                errSticky,
  output logic                asnMasked,
  output logic                descValid
);
  // assignment table
  logic              asnMaskT [NUM_SRC];
  logic [DESC_W-1:0] asnDescT [NUM_SRC];
  logic [DATA_W-1:0] asnDataT [NUM_SRC];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        asnMaskT[i] <= 1'b1;
        asnDescT[i] <= '0;
        asnDataT[i] <= '0;
      end
    end else if (asnWrEn) begin
      asnMaskT[asnWrSrc] <= asnWrMask;
      asnDescT[asnWrSrc] <= asnWrDesc;
      asnDataT[asnWrSrc] <= asnWrData;
    end
  end

  // event in flight
  logic [SRC_W-1:0]  srcReg;
  logic              curMasked;
  logic [DESC_W-1:0] curDesc;
  logic [DATA_W-1:0] curData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg    <= '0;
      curMasked <= 1'b1;
      curDesc   <= '0;
      curData   <= '0;
    end else begin
      if (strobes.latchSrc) srcReg <= notifySrc;
      if (strobes.latchAsn) begin
        curMasked <= asnMaskT[srcReg];
        curDesc   <= asnDescT[srcReg];
        curData   <= asnDataT[srcReg];
      end
    end
  end

  // descriptor table and per-queue index/toggle
  logic              dValid [NUM_DESC];
  logic [CPU_W-1:0]  dCpu   [NUM_DESC];
  logic [PRIO_W-1:0] dPrio  [NUM_DESC];
  logic [QA_W-1:0]   dBase  [NUM_DESC];
  logic [CNT_W-1:0]  dSize  [NUM_DESC];
  logic [CNT_W-1:0]  qIdx   [NUM_DESC];
  logic              qTog   [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    logic [CNT_W-1:0] idxInc;
    assign idxInc = qIdx[g] + CNT_W'(1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dValid[g] <= 1'b0;
        dCpu[g]   <= '0;
        dPrio[g]  <= '0;
        dBase[g]  <= '0;
        dSize[g]  <= CNT_W'(1);
        qIdx[g]   <= '0;
        qTog[g]   <= 1'b1;
      end else if (descWrEn && descWrIdx == DESC_W'(g)) begin
        dValid[g] <= descWrValid;
        dCpu[g]   <= descWrCpu;
        dPrio[g]  <= descWrPrio;
        dBase[g]  <= descWrBase;
        dSize[g]  <= descWrSize;
        qIdx[g]   <= '0;
        qTog[g]   <= 1'b1;
      end else if (strobes.qWrite && curDesc == DESC_W'(g)) begin
        if (idxInc == dSize[g]) begin
          qIdx[g] <= '0;
          qTog[g] <= ~qTog[g];
        end else begin
          qIdx[g] <= idxInc;
        end
      end
    end
  end

  // queue memory
  logic [31:0]     qMem [QMEM_DEPTH];
  logic [QA_W-1:0] wrAddr;
  assign wrAddr = dBase[curDesc] + qIdx[curDesc][QA_W-1:0];

  always_ff @(posedge clk) begin
    if (strobes.qWrite) qMem[wrAddr] <= {qTog[curDesc], curData};
  end
  assign qRdData = qMem[qRdAddr];

  // presentation and error
  logic [CPU_W-1:0]  presCpuR;
  logic [PRIO_W-1:0] presPrioR;
  logic              errR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presCpuR  <= '0;
      presPrioR <= '0;
      errR      <= 1'b0;
    end else begin
      if (strobes.qWrite) begin
        presCpuR  <= dCpu[curDesc];
        presPrioR <= dPrio[curDesc];
      end
      if (strobes.setErr) errR <= 1'b1;
    end
  end

  assign presCpu   = presCpuR;
  assign presPrio  = presPrioR;
  assign errSticky = errR;
  assign asnMasked = curMasked;
  assign descValid = dValid[curDesc];

  logic wrapNow;
  assign wrapNow = (qIdx[curDesc] + CNT_W'(1)) == dSize[curDesc];

  // R5
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.qWrite && !descWrEn && wrapNow) |=>
      (qIdx[curDesc] == '0 && qTog[curDesc] != $past(qTog[curDesc])));
  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.qWrite && !descWrEn && !wrapNow) |=>
      (qIdx[curDesc] == CNT_W'($past(qIdx[curDesc]) + CNT_W'(1))));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errR |=> errR);
endmodule

// File: rtl/evt_route_engine.sv
module evt_route_engine
  import erq_pkg::*;
#(
  parameter int NUM_SRC    = 16,
  parameter int NUM_DESC   = 4,
  parameter int NUM_CPU    = 4,
  parameter int QMEM_DEPTH = 64,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int DESC_W = $clog2(NUM_DESC),
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int QA_W   = $clog2(QMEM_DEPTH),
  localparam int CNT_W  = QA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              notifyValid,
  input  logic [SRC_W-1:0]  notifySrc,
  output logic              notifyReady,
  input  logic              asnWrEn,
  input  logic [SRC_W-1:0]  asnWrSrc,
  input  logic              asnWrMask,
  input  logic [DESC_W-1:0] asnWrDesc,
  input  logic [30:0]       asnWrData,
  input  logic              descWrEn,
  input  logic [DESC_W-1:0] descWrIdx,
  input  logic              descWrValid,
  input  logic [CPU_W-1:0]  descWrCpu,
  input  logic [2:0]        descWrPrio,
  input  logic [QA_W-1:0]   descWrBase,
  input  logic [CNT_W-1:0]  descWrSize,
  input  logic [QA_W-1:0]   qRdAddr,
  output logic [31:0]       qRdData,
  output logic              presValid,
  output logic [CPU_W-1:0]  presCpu,
  output logic [2:0]        presPrio,
  output logic              errSticky
);
  erq_strobe_t strobes;
  logic        asnMasked;
  logic        descValid;

  erq_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .notifyValid (notifyValid),
    .asnMasked   (asnMasked),
    .descValid   (descValid),
    .notifyReady (notifyReady),
    .presValid   (presValid),
    .strobes     (strobes)
  );

  erq_datapath #(
    .NUM_SRC    (NUM_SRC),
    .NUM_DESC   (NUM_DESC),
    .NUM_CPU    (NUM_CPU),
    .QMEM_DEPTH (QMEM_DEPTH)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .notifySrc   (notifySrc),
    .asnWrEn     (asnWrEn),
    .asnWrSrc    (asnWrSrc),
    .asnWrMask   (asnWrMask),
    .asnWrDesc   (asnWrDesc),
    .asnWrData   (asnWrData),
    .descWrEn    (descWrEn),
    .descWrIdx   (descWrIdx),
    .descWrValid (descWrValid),
    .descWrCpu   (descWrCpu),
    .descWrPrio  (descWrPrio),
    .descWrBase  (descWrBase),
    .descWrSize  (descWrSize),
    .qRdAddr     (qRdAddr),
    .qRdData     (qRdData),
    .presCpu     (presCpu),
    .presPrio    (presPrio),
    .errSticky   (errSticky),
    .asnMasked   (asnMasked),
    .descValid   (descValid)
  );
endmodule

// File: tb/evt_route_engine_tb_top.sv
module evt_route_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        notifyValid = 1'b0;
  logic [3:0]  notifySrc = '0;
  logic        notifyReady;
  logic        asnWrEn = 1'b0;
  logic [3:0]  asnWrSrc = '0;
  logic        asnWrMask = 1'b0;
  logic [1:0]  asnWrDesc = '0;
  logic [30:0] asnWrData = '0;
  logic        descWrEn = 1'b0;
  logic [1:0]  descWrIdx = '0;
  logic        descWrValid = 1'b0;
  logic [1:0]  descWrCpu = '0;
  logic [2:0]  descWrPrio = '0;
  logic [5:0]  descWrBase = '0;
  logic [6:0]  descWrSize = '0;
  logic [5:0]  qRdAddr = '0;
  logic [31:0] qRdData;
  logic        presValid;
  logic [1:0]  presCpu;
  logic [2:0]  presPrio;
  logic        errSticky;

  always #10 clk = ~clk;

  evt_route_engine dut_i (.*);

  int nChecks = 0;
  int nBad = 0;

  // reference model
  bit          aMask [16];
  int          aDesc [16];
  logic [30:0] aData [16];
  bit          mValid [4];
  int          mCpu [4], mPrio [4], mBase [4], mSize [4], mIdx [4];
  bit          mTog [4];
  logic [31:0] expMem [64];
  bit          expWr [64];
  bit          expErr = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic progAsn(input int s, input bit m, input int d, input logic [30:0] data);
    @(negedge clk);
    asnWrEn = 1; asnWrSrc = 4'(s); asnWrMask = m; asnWrDesc = 2'(d); asnWrData = data;
    @(negedge clk);
    asnWrEn = 0;
    aMask[s] = m; aDesc[s] = d; aData[s] = data;
  endtask

  task automatic progDesc(input int d, input bit v, input int cpu, input int prio,
                          input int base, input int size);
    @(negedge clk);
    descWrEn = 1; descWrIdx = 2'(d); descWrValid = v; descWrCpu = 2'(cpu);
    descWrPrio = 3'(prio); descWrBase = 6'(base); descWrSize = 7'(size);
    @(negedge clk);
    descWrEn = 0;
    mValid[d] = v; mCpu[d] = cpu; mPrio[d] = prio; mBase[d] = base;
    mSize[d] = size; mIdx[d] = 0; mTog[d] = 1;
  endtask

  // offers source s; if junk, keeps notifyValid high with junkSrc while busy
  task automatic sendEvt(input int s, input bit junk, input int junkSrc);
    int d;
    bit routed;
    int last;
    int a;
    @(negedge clk);
    check("R2", "ready before offer", notifyReady, 1);
    notifyValid = 1; notifySrc = 4'(s);
    d = aDesc[s];
    routed = !aMask[s] && mValid[d];
    last = routed ? 4 : 2;
    @(posedge clk);
    #1;
    if (junk) notifySrc = 4'(junkSrc);
    else notifyValid = 0;
    for (int n = 0; n <= last; n++) begin
      @(negedge clk);
      if (n == last) notifyValid = 0;
      if (!routed && !aMask[s] && n == 2) expErr = 1;
      if (routed && n == 3) begin
        a = (mBase[d] + mIdx[d]) % 64;
        expMem[a] = {mTog[d], aData[s]};
        expWr[a] = 1;
        mIdx[d]++;
        if (mIdx[d] == mSize[d]) begin mIdx[d] = 0; mTog[d] = !mTog[d]; end
      end
      check("R2", "ready during event", notifyReady, (n == last) ? 1 : 0);
      check("R6", "presValid timing", presValid, (routed && n == 3) ? 1 : 0);
      check("R7", "errSticky", errSticky, expErr);
      if (routed && n == 3) begin
        check("R6", "presCpu", presCpu, mCpu[d]);
        check("R6", "presPrio", presPrio, mPrio[d]);
      end
    end
  endtask

  task automatic readMem(input int a, output logic [31:0] v);
    @(negedge clk);
    qRdAddr = 6'(a);
    #1;
    v = qRdData;
  endtask

  task automatic verifyMem(input string req);
    logic [31:0] v;
    for (int a = 0; a < 64; a++) begin
      if (expWr[a]) begin
        readMem(a, v);
        check(req, $sformatf("queue word @%0d", a), v, expMem[a]);
      end
    end
  endtask

  task automatic finish;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    finish();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin aMask[i] = 1; aDesc[i] = 0; aData[i] = '0; end
    for (int i = 0; i < 4; i++) begin
      mValid[i] = 0; mCpu[i] = 0; mPrio[i] = 0; mBase[i] = 0; mSize[i] = 1;
      mIdx[i] = 0; mTog[i] = 1;
    end
    for (int i = 0; i < 64; i++) begin expWr[i] = 0; expMem[i] = '0; end

    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1
    check("R1", "reset ready", notifyReady, 1);
    check("R1", "reset presValid", presValid, 0);
    check("R1", "reset errSticky", errSticky, 0);

    progDesc(0, 1, 1, 5, 0, 3);
    progDesc(1, 1, 2, 0, 8, 4);
    progDesc(3, 1, 3, 7, 20, 1);
    progAsn(0, 0, 0, 31'h0000_0A0A);
    progAsn(1, 0, 0, 31'h7000_0B0B);
    progAsn(2, 1, 1, 31'h0000_0C0C);
    progAsn(3, 0, 2, 31'h0000_0D0D);
    progAsn(4, 0, 1, 31'h1234_5678);
    progAsn(5, 0, 3, 31'h0055_AA55);

    // R9: two sources sharing descriptor 0, wrapping after three (R5)
    sendEvt(0, 0, 0);
    sendEvt(1, 0, 0);
    sendEvt(0, 0, 0);
    readMem(0, v); check("R9", "slot0 first pass", v, {1'b1, 31'h0000_0A0A});
    readMem(1, v); check("R9", "slot1 first pass", v, {1'b1, 31'h7000_0B0B});
    readMem(2, v); check("R9", "slot2 first pass", v, {1'b1, 31'h0000_0A0A});
    sendEvt(1, 0, 0);
    readMem(0, v); check("R5", "slot0 after wrap, toggle 0", v, {1'b0, 31'h7000_0B0B});

    // R3: masked source, then descriptor 1 must still start at index 0
    sendEvt(2, 0, 0);
    check("R3", "no error after masked", errSticky, 0);
    sendEvt(4, 0, 0);
    readMem(8, v); check("R3", "desc1 slot0 after masked", v, {1'b1, 31'h1234_5678});

    // R7: invalid descriptor
    sendEvt(3, 0, 0);
    sendEvt(0, 0, 0);
    check("R7", "error stays set", errSticky, 1);

    // R5: single-entry queue flips toggle each write
    sendEvt(5, 0, 0);
    readMem(20, v); check("R5", "size1 first", v, {1'b1, 31'h0055_AA55});
    sendEvt(5, 0, 0);
    readMem(20, v); check("R5", "size1 second", v, {1'b0, 31'h0055_AA55});

    // R10: offers held during busy are ignored
    sendEvt(4, 1, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10", "no extra presentation", presValid, 0);
      check("R10", "stays ready", notifyReady, 1);
    end
    sendEvt(4, 0, 0);
    readMem(10, v); check("R10", "desc1 slot2 follows slot1", v, {1'b1, 31'h1234_5678});

    // R8: reprogram descriptor 0 mid-use
    progDesc(0, 1, 0, 2, 40, 2);
    progAsn(1, 0, 0, 31'h0000_1111);
    sendEvt(1, 0, 0);
    readMem(40, v); check("R8", "restart at base, toggle 1", v, {1'b1, 31'h0000_1111});
    sendEvt(0, 0, 0);
    sendEvt(1, 0, 0);
    readMem(40, v); check("R8", "wrap of new queue", v, {1'b0, 31'h0000_1111});

    verifyMem("R4");
    finish();
  end
endmodule